// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block is a management-bus master for external Ethernet PHYs. Software talks to it through four 32-bit words on a simple single-cycle register bus: a configuration/status word, a command word, a data word and an address word. From these it sets the serial clock rate, chooses between the short (Clause 22) and extended (Clause 45) frame layouts, and launches address, write and read frames. The block generates the management clock (MDC), drives the bidirectional data line through a value/enable pair, and samples the line during the PHY's part of a read.

A frame starts when software writes one of the launching fields. While a frame is in flight, a busy flag reads as set in two places. When a read completes, the returned 16 bits appear in the data word. If the PHY does not claim the turnaround slot, an error flag is raised. Further launch attempts are dropped until the bus is idle again. The command word also holds a scan-enable bit and an auto-increment bit. Both are kept for readback and have no other effect.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset all four words (index 0 config/status, 1 command, 2 data, 3 address) read as zero, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: MDC is a free-running square wave whose level toggles every max(2, 2 × D) system clocks, where D is config bits 15:8.
- R3: With config bit 6 at 0, writing data bits 15:0 sends 32 ones, then `01`, `01`, the 5-bit PHY number (command bits 9:5), the 5-bit register number (command bits 4:0), `10`, and the 16 data bits. All bits go MSB first, 64 in total.
- R4: With config bit 6 at 0, writing the command word with bit 15 set sends 32 ones, `01`, `10`, the PHY number and the register number, then releases the line. The 16 bits the PHY returns are then readable in data bits 15:0. Config bit 0 and data bit 31 read 1 from the cycle after any launch until the frame ends.
- R5: With config bit 6 at 1, writing the address word sends 32 ones, `00`, `00`, port (command 9:5), device (command 4:0), `10`, and the address bits 15:0. With config bit 6 at 0, an address write only stores the value and sends nothing.
- R6: With config bit 6 at 1, a data write uses start `00`, op `01`. A read uses start `00`, op `11`, and returns the PHY's 16 bits in data bits 15:0.
- R7: With command bit 10 set, the 32-bit preamble is left out of every frame type.
- R8: When the line is still high in the second turnaround slot of a read, config bit 1 becomes 1. It returns to 0 when the next read frame begins.
- R9: A launching write (data word, address word in extended mode, or command with bit 15) made while busy is dropped. The word keeps its old value and no extra frame is sent.
- R10: `mdio_o` and `mdio_oe` change only when MDC falls, so they are stable at each MDC rise. During a read the enable is low from the first turnaround slot to the end of the frame.
- R11: Command bits 11 and 14 read back as written and leave the frame content unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index (0 config/status, 1 command, 2 data, 3 address) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Sampled serial data line |

## Verification
The hardest states to reach from the ports are the read-error path and its clearing. The error appears only when nothing drives the second turnaround slot low. It clears only when the following read's frame actually starts. The bench models a PHY that counts MDC falls after the master releases the line. That PHY either answers with a chosen word or stays silent, so the line floats high. Launch attempts made while busy are placed a few cycles into a running frame. The bench then checks that both the frame bit count and the stored words are unchanged.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    typedef enum logic [1:0] {
        K_ADDR  = 2'd0,
        K_WRITE = 2'd1,
        K_READ  = 2'd2
    } kind_e;

    localparam logic [1:0] W_CFG = 2'd0;
    localparam logic [1:0] W_CMD = 2'd1;
    localparam logic [1:0] W_DAT = 2'd2;
    localparam logic [1:0] W_ADR = 2'd3;

    localparam int unsigned CFG_BUSY  = 0;
    localparam int unsigned CFG_ERR   = 1;
    localparam int unsigned CFG_EXT   = 6;
    localparam int unsigned CFG_DIV   = 8;
    localparam int unsigned CMD_RD    = 15;
    localparam int unsigned DAT_BUSY  = 31;

    // stored command bits: read, auto-inc, scan, no-preamble, port, device
    localparam logic [15:0] CMD_KEEP = 16'hCFFF;

    typedef struct packed {
        logic [4:0]  port;
        logic [4:0]  dev;
        logic        no_pre;
        logic        ext;
        logic [15:0] payload;
        kind_e       kind;
    } frame_req_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int HW = DIV_W + 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          lvl;
    } gen_t;

    gen_t          s_q, s_d;
    logic [HW-1:0] half;

    always_comb begin
        half = {div, 1'b0};
        if (half < HW'(2)) half = HW'(2);
        s_d      = s_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (s_q.cnt >= half - HW'(1)) begin
            s_d.cnt  = '0;
            s_d.lvl  = ~s_q.lvl;
            rise_stb = ~s_q.lvl;
            fall_stb = s_q.lvl;
        end else begin
            s_d.cnt = s_q.cnt + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.lvl;

endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall_stb,
    input  logic        rise_stb,
    input  logic        start,
    input  frame_req_t  req,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err
);
    localparam int BODY_W  = 32;
    localparam int FRAME_W = PRE_LEN + BODY_W;
    localparam int CW      = $clog2(FRAME_W + 1);
    localparam int TA2_POS = 16;
    localparam int REL_POS = 18;

    typedef struct packed {
        logic               busy;
        logic               is_rd;
        logic [CW-1:0]      rem;
        logic [FRAME_W-1:0] sh;
        logic               o;
        logic               oe;
        logic [15:0]        rsh;
        logic               err;
        logic               done;
    } eng_t;

    eng_t        s_q, s_d;
    logic [1:0]  st, op, ta;
    logic [31:0] body;

    always_comb begin
        st = req.ext ? 2'b00 : 2'b01;
        unique case (req.kind)
            K_ADDR:  op = 2'b00;
            K_WRITE: op = 2'b01;
            default: op = req.ext ? 2'b11 : 2'b10;
        endcase
        ta   = (req.kind == K_READ) ? 2'b11 : 2'b10;
        body = {st, op, req.port, req.dev, ta, req.payload};

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.is_rd = (req.kind == K_READ);
                s_d.rem   = req.no_pre ? CW'(BODY_W) : CW'(FRAME_W);
                s_d.sh    = req.no_pre ? {body, {PRE_LEN{1'b1}}}
                                       : {{PRE_LEN{1'b1}}, body};
                if (req.kind == K_READ) s_d.err = 1'b0;
            end
        end else if (fall_stb) begin
            if (s_q.rem == '0) begin
                s_d.busy = 1'b0;
                s_d.oe   = 1'b0;
                s_d.o    = 1'b1;
                s_d.done = 1'b1;
            end else begin
                s_d.o   = s_q.sh[FRAME_W-1];
                s_d.oe  = !(s_q.is_rd && (s_q.rem <= CW'(REL_POS)));
                s_d.sh  = {s_q.sh[FRAME_W-2:0], 1'b0};
                s_d.rem = s_q.rem - CW'(1);
            end
        end else if (rise_stb && s_q.is_rd) begin
            if (s_q.rem == CW'(TA2_POS)) begin
                s_d.err = mdio_i;
            end else if (s_q.rem < CW'(TA2_POS)) begin
                s_d.rsh = {s_q.rsh[14:0], mdio_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= '0;
            s_q.o <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdio_o  = s_q.o;
    assign mdio_oe = s_q.oe;
    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rd_data = s_q.rsh;
    assign rd_err  = s_q.err;

endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
module mdio_csr
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic [15:0]      eng_rd_data,
    input  logic             eng_rd_err,
    output logic [DIV_W-1:0] div,
    output logic             start,
    output frame_req_t       req
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             ext;
        logic [15:0]      cmd;
        logic [15:0]      dat;
        logic [15:0]      adr;
        logic             start;
        kind_e            kind;
    } csr_t;

    csr_t s_q, s_d;
    logic busy_all;
    logic unused_hi;

    assign busy_all  = eng_busy | s_q.start;
    assign unused_hi = ^bus_wdata[31:16];

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (eng_done && (s_q.kind == K_READ)) s_d.dat = eng_rd_data;
        if (bus_wr) begin
            unique case (bus_addr)
                W_CFG: begin
                    s_d.div = bus_wdata[CFG_DIV +: DIV_W];
                    s_d.ext = bus_wdata[CFG_EXT];
                end
                W_CMD: begin
                    if (!bus_wdata[CMD_RD]) begin
                        s_d.cmd = bus_wdata[15:0] & CMD_KEEP;
                    end else if (!busy_all) begin
                        s_d.cmd   = bus_wdata[15:0] & CMD_KEEP;
                        s_d.start = 1'b1;
                        s_d.kind  = K_READ;
                    end
                end
                W_DAT: begin
                    if (!busy_all) begin
                        s_d.dat   = bus_wdata[15:0];
                        s_d.start = 1'b1;
                        s_d.kind  = K_WRITE;
                    end
                end
                default: begin
                    if (!s_q.ext) begin
                        s_d.adr = bus_wdata[15:0];
                    end else if (!busy_all) begin
                        s_d.adr   = bus_wdata[15:0];
                        s_d.start = 1'b1;
                        s_d.kind  = K_ADDR;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            W_CFG: begin
                bus_rdata[CFG_BUSY]          = busy_all;
                bus_rdata[CFG_ERR]           = eng_rd_err;
                bus_rdata[CFG_EXT]           = s_q.ext;
                bus_rdata[CFG_DIV +: DIV_W]  = s_q.div;
            end
            W_CMD: bus_rdata[15:0] = s_q.cmd;
            W_DAT: begin
                bus_rdata[15:0]     = s_q.dat;
                bus_rdata[DAT_BUSY] = busy_all;
            end
            default: bus_rdata[15:0] = s_q.adr;
        endcase
    end

    assign div         = s_q.div;
    assign start       = s_q.start;
    assign req.port    = s_q.cmd[9:5];
    assign req.dev     = s_q.cmd[4:0];
    assign req.no_pre  = s_q.cmd[10];
    assign req.ext     = s_q.ext;
    assign req.payload = (s_q.kind == K_ADDR) ? s_q.adr : s_q.dat;
    assign req.kind    = s_q.kind;

endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             rise_stb, fall_stb;
    logic [DIV_W-1:0] div;
    logic             start;
    frame_req_t       req;
    logic             eng_busy, eng_done, eng_rd_err;
    logic [15:0]      eng_rd_data;
    logic             start_is_read;

    assign start_is_read = (req.kind == K_READ);

    mdio_csr #(.DIV_W(DIV_W)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_rd_data (eng_rd_data),
        .eng_rd_err  (eng_rd_err),
        .div         (div),
        .start       (start),
        .req         (req)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .start    (start),
        .req      (req),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (eng_busy),
        .done     (eng_done),
        .rd_data  (eng_rd_data),
        .rd_err   (eng_rd_err)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic eng_busy,
    input logic start,
    input logic start_is_read,
    input logic rd_err
);
    // R10: data changes only together with an MDC fall
    p_data_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R10: enable changes only together with an MDC fall
    p_oe_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $fell(mdc));

    // R10: line is driven only inside a frame
    p_oe_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> eng_busy);

    // R9: a launch never reaches a busy sequencer
    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !eng_busy);

    // R8: a starting read clears the error flag
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_is_read) |=> !rd_err);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mdc           (mdc),
    .mdio_o        (mdio_o),
    .mdio_oe       (mdio_oe),
    .eng_busy      (eng_busy),
    .start         (start),
    .start_is_read (start_is_read),
    .rd_err        (eng_rd_err)
);

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int ntests = 0;
    int nfail  = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mdio_mgmt_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: answers reads after the master releases the line
    logic        phy_drv = 1'b1;
    bit          phy_answer = 1'b0;
    logic [15:0] phy_val = '0;
    bit          rd_act = 1'b0;
    bit          seen_oe = 1'b0;
    int          slot = 0;
    assign mdio_i = phy_drv;

    always @(negedge mdc) begin
        #1;
        if (rd_act) begin
            if (mdio_oe) begin
                seen_oe = 1'b1; slot = 0; phy_drv = 1'b1;
            end else if (seen_oe) begin
                slot++;
                if (slot == 2)                    phy_drv = phy_answer ? 1'b0 : 1'b1;
                else if (slot >= 3 && slot <= 18) phy_drv = phy_answer ? phy_val[18-slot] : 1'b1;
                else                              phy_drv = 1'b1;
            end
        end else begin
            phy_drv = 1'b1;
        end
    end

    // monitor: driven bits captured at MDC rise
    logic [63:0] cap = '0;
    int          ncap = 0;
    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap = {cap[62:0], mdio_o};
            ncap++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 20000; k++) begin
            bus_read(2'd0, v);
            if (!v[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_cap();
        cap = '0; ncap = 0;
    endtask

    function automatic logic [63:0] mk(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [1:0] ta, input logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, a, b, ta, d};
    endfunction

    function automatic logic [31:0] cmdw(input logic [4:0] a, input logic [4:0] b,
                                         input bit rd, input bit nopre);
        return (32'(rd) << 15) | (32'(nopre) << 10) | (32'(a) << 5) | 32'(b);
    endfunction

    task automatic do_read(input string tag, input logic [4:0] a, input logic [4:0] b,
                           input bit ext, input bit nopre, input bit answer,
                           input logic [15:0] val);
        logic [31:0] v;
        logic [63:0] e;
        phy_answer = answer; phy_val = val; seen_oe = 1'b0; rd_act = 1'b1;
        clear_cap();
        bus_write(2'd1, cmdw(a, b, 1'b1, nopre));
        wait_idle();
        rd_act = 1'b0;
        e = mk(ext ? 2'b00 : 2'b01, ext ? 2'b11 : 2'b10, a, b, 2'b11, 16'h0);
        if (nopre) begin
            chk({tag, " R10 driven bit count"}, 64'(ncap), 64'd14);
            chk({tag, " header bits"}, 64'(cap[13:0]), 64'(e[31:18]));
        end else begin
            chk({tag, " R10 driven bit count"}, 64'(ncap), 64'd46);
            chk({tag, " header bits"}, 64'(cap[45:0]), 64'(e[63:18]));
        end
        bus_read(2'd2, v);
        chk({tag, " returned data"}, 64'(v[15:0]), answer ? 64'(val) : 64'hFFFF);
        bus_read(2'd0, v);
        chk({tag, " R8 error flag"}, 64'(v[1]), answer ? 64'd0 : 64'd1);
    endtask

    task automatic do_write(input string tag, input logic [4:0] a, input logic [4:0] b,
                            input bit ext, input bit nopre, input logic [15:0] d);
        logic [31:0] v;
        logic [63:0] e;
        bus_write(2'd1, cmdw(a, b, 1'b0, nopre));
        clear_cap();
        bus_write(2'd2, 32'(d));
        bus_read(2'd0, v);
        chk({tag, " R4 status busy"}, 64'(v[0]), 64'd1);
        bus_read(2'd2, v);
        chk({tag, " R4 data busy"}, 64'(v[31]), 64'd1);
        wait_idle();
        e = mk(ext ? 2'b00 : 2'b01, 2'b01, a, b, 2'b10, d);
        if (nopre) begin
            chk({tag, " bit count"}, 64'(ncap), 64'd32);
            chk({tag, " frame"}, 64'(cap[31:0]), 64'(e[31:0]));
        end else begin
            chk({tag, " bit count"}, 64'(ncap), 64'd64);
            chk({tag, " frame"}, cap, e);
        end
    endtask

    initial begin
        logic [31:0] v;
        realtime t0, t1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), v);
            chk("R1 reset word", 64'(v), 64'd0);
        end
        chk("R1 idle pins", 64'({mdio_oe, mdio_o}), 64'd1);

        // R2: divider sweep
        for (int d = 0; d < 5; d++) begin
            bus_write(2'd0, 32'(d) << 8);
            @(posedge mdc); @(posedge mdc);
            t0 = $realtime;
            @(posedge mdc);
            t1 = $realtime;
            chk("R2 MDC period", 64'(int'((t1 - t0) / CLK_P)),
                64'(2 * ((2 * d < 2) ? 2 : 2 * d)));
        end
        bus_write(2'd0, 32'h100);

        // R3: short-format writes
        for (int i = 0; i < 4; i++)
            do_write("R3 write", 5'((i * 9 + 1) % 32), 5'((i * 7 + 3) % 32), 1'b0, 1'b0,
                     16'hA5C3 ^ 16'(i * 16'h1111));

        // R4: short-format reads with several return patterns
        for (int i = 0; i < 3; i++)
            do_read("R4 read", 5'(i * 11 % 32), 5'(31 - i), 1'b0, 1'b0, 1'b1,
                    16'h8001 ^ 16'(i * 16'h3C5A));

        // R8: silent PHY, then flag clears when the next read starts
        do_read("R8 silent read", 5'd4, 5'd2, 1'b0, 1'b0, 1'b0, 16'h0);
        phy_answer = 1'b1; phy_val = 16'h1234; seen_oe = 1'b0; rd_act = 1'b1;
        clear_cap();
        bus_write(2'd1, cmdw(5'd4, 5'd2, 1'b1, 1'b0));
        repeat (2) @(negedge clk);
        bus_read(2'd0, v);
        chk("R8 error cleared at read start", 64'(v[1:0]), 64'd1);
        wait_idle();
        rd_act = 1'b0;
        bus_read(2'd2, v);
        chk("R8 answered read data", 64'(v[15:0]), 64'h1234);

        // R9: launches while busy are dropped
        bus_write(2'd1, cmdw(5'd6, 5'd9, 1'b0, 1'b0));
        clear_cap();
        bus_write(2'd2, 32'h0000_BEEF);
        repeat (4) @(negedge clk);
        bus_write(2'd2, 32'h0000_1111);
        bus_write(2'd1, cmdw(5'd1, 5'd1, 1'b1, 1'b0));
        wait_idle();
        chk("R9 one frame only", 64'(ncap), 64'd64);
        chk("R9 frame of first write", cap, mk(2'b01, 2'b01, 5'd6, 5'd9, 2'b10, 16'hBEEF));
        bus_read(2'd2, v);
        chk("R9 data word kept", 64'(v[15:0]), 64'hBEEF);
        bus_read(2'd1, v);
        chk("R9 command word kept", 64'(v[15:0]), 64'(cmdw(5'd6, 5'd9, 1'b0, 1'b0)));

        // R7: no preamble
        do_write("R7 write", 5'd17, 5'd30, 1'b0, 1'b1, 16'h5AA5);
        do_read("R7 read", 5'd3, 5'd12, 1'b0, 1'b1, 1'b1, 16'hC00C);

        // R11: stored control bits have no effect
        bus_write(2'd1, cmdw(5'd2, 5'd5, 1'b0, 1'b0) | 32'h4800);
        bus_read(2'd1, v);
        chk("R11 readback", 64'(v[15:0]), 64'(cmdw(5'd2, 5'd5, 1'b0, 1'b0) | 32'h4800));
        clear_cap();
        bus_write(2'd2, 32'h0000_0F0F);
        wait_idle();
        chk("R11 frame unchanged", cap, mk(2'b01, 2'b01, 5'd2, 5'd5, 2'b10, 16'h0F0F));

        // R5: address word in short mode sends nothing
        clear_cap();
        bus_write(2'd3, 32'h0000_7E57);
        repeat (60) @(negedge clk);
        chk("R5 no frame in short mode", 64'(ncap), 64'd0);
        bus_read(2'd3, v);
        chk("R5 address stored", 64'(v[15:0]), 64'h7E57);

        // R5, R6: extended format
        bus_write(2'd0, 32'h140);
        bus_write(2'd1, cmdw(5'd21, 5'd7, 1'b0, 1'b0));
        clear_cap();
        bus_write(2'd3, 32'h0000_C0DE);
        wait_idle();
        chk("R5 address frame count", 64'(ncap), 64'd64);
        chk("R5 address frame", cap, mk(2'b00, 2'b00, 5'd21, 5'd7, 2'b10, 16'hC0DE));
        do_write("R6 ext write", 5'd21, 5'd7, 1'b1, 1'b0, 16'h9876);
        do_read("R6 ext read", 5'd21, 5'd7, 1'b1, 1'b0, 1'b1, 16'h4321);
        do_read("R6 ext read no pre", 5'd8, 5'd1, 1'b1, 1'b1, 1'b1, 16'hFACE);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

endmodule